// File: doc/BRIEF.md
# Sensor Fault Limp-Mode Supervisor

This block watches the engine's sampled sensor values and turns them into a seven-bit fault mask. Manifold pressure and throttle position must stay inside a window. Coolant and intake temperature must not rise above a ceiling, and battery voltage must not fall below a floor. An expander-failure flag from the I/O subsystem feeds the mask directly. Oil pressure is checked either as a switch level or as a sender voltage, and only once the engine has been running long enough for pressure to build.

Any fault puts the supervisor into a reduced-capability state at once. While in that state it replaces the rev limit with a configured limp value and clamps spark advance to a ceiling. It also holds the transmission in its current gear, releases the converter clutch and lights the warning lamp. Leaving the state is deliberately slow: the mask must stay completely clear for a configured number of millisecond ticks, and any fault during that wait starts the count over. Outside the limp state the requested rev limit and advance pass through unchanged. All thresholds arrive as inputs from a configuration store outside the block.

Top module: `limp_supervisor`

## Requirements
- R1: `fault_mask` is a register that updates on every clock from the inputs present at that edge and is all zero after reset. Its bit positions are: bit0 manifold pressure, bit1 throttle, bit2 coolant, bit3 intake air, bit4 battery, bit5 expander, bit6 oil.
- R2: The manifold-pressure and throttle bits are set when the value lies below its minimum or above its maximum. A value equal to either bound is not a fault.
- R3: The coolant and intake-air bits are set when the value is strictly above its maximum. The battery bit is set when the value is strictly below its minimum.
- R4: Bit5 copies `expander_fault`.
- R5: The oil bit can be set only while `rpm` is at least RUN_RPM (400). The engine must also have stayed at or above that speed for `cfg_start_ms` tick pulses. A drop below RUN_RPM clears the oil bit on the next update and restarts the delay.
- R6: In sender mode (`cfg_oil_mode` = 2'b10), pressure in PSI is (oil_mv − 500) × cfg_oil_full_psi / 4000. The oil bit is set when this pressure is below `cfg_oil_min_psi`. A voltage under 500 mV counts as 0 PSI.
- R7: In switch mode (2'b01), `cfg_oil_active_low` = 1 means an `oil_sw` level of 0 is low pressure, and `cfg_oil_active_low` = 0 means a level of 1 is low pressure. Mode 2'b00 never sets the oil bit.
- R8: `limp_active` is set on the same clock edge that loads a nonzero mask.
- R9: `limp_active` clears on the `cfg_recover_ms`-th `tick_ms` pulse counted while the mask is all clear. A fault during the wait restarts the count from zero.
- R10: While limp is active, `rev_limit` equals `cfg_limp_rev` and `adv_limit` is the signed minimum of `req_adv` and `cfg_adv_cap`. `gear_lock`, `tcc_release` and `warn_lamp` are all 1.
- R11: While limp is inactive, `rev_limit` equals `req_rev`, `adv_limit` equals `req_adv`, and the three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| map_val | input | SENS_W | Manifold pressure sample |
| tps_val | input | SENS_W | Throttle position sample |
| clt_val | input | SENS_W | Coolant temperature sample |
| iat_val | input | SENS_W | Intake air temperature sample |
| vbat_val | input | SENS_W | Battery voltage sample |
| rpm | input | RPM_W | Engine speed |
| expander_fault | input | 1 | I/O expander health failure |
| oil_sw | input | 1 | Oil pressure switch level |
| oil_mv | input | MV_W | Oil sender voltage in millivolts |
| cfg_map_min | input | SENS_W | Manifold pressure lower bound |
| cfg_map_max | input | SENS_W | Manifold pressure upper bound |
| cfg_tps_min | input | SENS_W | Throttle lower bound |
| cfg_tps_max | input | SENS_W | Throttle upper bound |
| cfg_clt_max | input | SENS_W | Coolant ceiling |
| cfg_iat_max | input | SENS_W | Intake air ceiling |
| cfg_vbat_min | input | SENS_W | Battery floor |
| cfg_oil_mode | input | 2 | 00 off, 01 switch, 10 sender |
| cfg_oil_active_low | input | 1 | Switch polarity |
| cfg_oil_full_psi | input | PSI_W | Sender full-scale pressure |
| cfg_oil_min_psi | input | PSI_W | Low-pressure threshold |
| cfg_start_ms | input | TIME_W | Post-start delay in ticks |
| cfg_recover_ms | input | TIME_W | All-clear hold in ticks |
| cfg_limp_rev | input | RPM_W | Rev limit while in limp |
| cfg_adv_cap | input | ADV_W | Signed advance ceiling while in limp |
| req_rev | input | RPM_W | Normal rev limit |
| req_adv | input | ADV_W | Signed requested advance |
| fault_mask | output | 7 | Registered fault bits |
| limp_active | output | 1 | Limp state |
| rev_limit | output | RPM_W | Effective rev limit |
| adv_limit | output | ADV_W | Effective signed advance |
| gear_lock | output | 1 | Hold current gear |
| tcc_release | output | 1 | Release converter clutch |
| warn_lamp | output | 1 | Warning lamp drive |

## Verification
The embedded assertions check the following on every cycle:
- a nonzero mask is never seen without limp being active;
- limp only ever falls on a tick after an all-clear cycle;
- a fault always zeroes the hold counter;
- the oil delay only arms while the engine is running, and a low speed disarms it;
- the manifold bit is backed by an out-of-window sample;
- the limp advance never exceeds the cap.

The exact number of ticks before exit, the restart of the hold when a fault reappears, and the restart of the start delay can only be shown by the scenarios. The same holds for the inclusive threshold bounds, the sender arithmetic at 10 PSI and the switch polarity.

// File: rtl/limp_pkg.sv
package limp_pkg;
   localparam int NUM_FAULTS = 7;
   localparam int NUM_SENS   = 5;
   localparam int FB_MAP  = 0;
   localparam int FB_TPS  = 1;
   localparam int FB_CLT  = 2;
   localparam int FB_IAT  = 3;
   localparam int FB_VBAT = 4;
   localparam int FB_EXP  = 5;
   localparam int FB_OIL  = 6;

   typedef enum logic [1:0] {
      OIL_OFF    = 2'b00,
      OIL_SWITCH = 2'b01,
      OIL_SENDER = 2'b10
   } oil_mode_e;
endpackage

// File: rtl/limp_range_check.sv
module limp_range_check #(
   parameter int W = 12
) (
   input  logic [W-1:0] value,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic         bad
);
   // A sensor is healthy only inside the inclusive window [lo, hi].
   assign bad = (value < lo) || (value > hi);
endmodule

// File: rtl/limp_oil_monitor.sv
module limp_oil_monitor #(
   parameter int RPM_W   = 14,
   parameter int MV_W    = 13,
   parameter int PSI_W   = 8,
   parameter int TIME_W  = 16,
   parameter int RUN_RPM = 400,
   parameter int ZERO_MV = 500,
   parameter int SPAN_MV = 4000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic [RPM_W-1:0]  rpm,
   input  logic              oil_sw,
   input  logic [MV_W-1:0]   oil_mv,
   input  logic [1:0]        cfg_mode,
   input  logic              cfg_active_low,
   input  logic [PSI_W-1:0]  cfg_full_psi,
   input  logic [PSI_W-1:0]  cfg_min_psi,
   input  logic [TIME_W-1:0] cfg_start_ms,
   output logic              oil_fault
);
   import limp_pkg::*;

   localparam int PROD_W = MV_W + PSI_W + 2;

   if (SPAN_MV >= (1 << (MV_W + 1))) begin : g_bad_span
      $error("SPAN_MV does not fit the product width");
   end

   logic              running;
   logic              armed;
   logic [TIME_W-1:0] run_cnt;
   logic [TIME_W:0]   run_next;
   logic              low_press;
   logic [PROD_W-1:0] mv_ext;
   logic [PROD_W-1:0] lhs;
   logic [PROD_W-1:0] rhs;

   assign running  = rpm >= RPM_W'(RUN_RPM);
   assign run_next = {1'b0, run_cnt} + 1'b1;

   // Post-start delay: counts ticks while running, restarts below RUN_RPM.
   always_ff @(posedge clk) begin
      if (!rst_n || !running) begin
         run_cnt <= '0;
         armed   <= 1'b0;
      end else if (tick_ms && !armed) begin
         if (run_next >= {1'b0, cfg_start_ms}) armed   <= 1'b1;
         else                                  run_cnt <= run_next[TIME_W-1:0];
      end
   end

   // Sender compare without division: (mv-zero)*full < min*span.
   assign mv_ext = PROD_W'(oil_mv);
   assign lhs    = (mv_ext - PROD_W'(ZERO_MV)) * PROD_W'(cfg_full_psi);
   assign rhs    = PROD_W'(cfg_min_psi) * PROD_W'(SPAN_MV);

   always_comb begin
      case (oil_mode_e'(cfg_mode))
         OIL_SWITCH: low_press = cfg_active_low ? ~oil_sw : oil_sw;
         OIL_SENDER: begin
            if (mv_ext < PROD_W'(ZERO_MV)) low_press = (cfg_min_psi != '0);
            else                           low_press = lhs < rhs;
         end
         default:    low_press = 1'b0;
      endcase
   end

   assign oil_fault = armed && running && low_press;

   // R5: arming only happens while the engine runs
   assert_arm_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(rpm >= RPM_W'(RUN_RPM)));
   // R5: a low speed always disarms the delay
   assert_slow_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rpm < RPM_W'(RUN_RPM)) |=> !armed);
endmodule

// File: rtl/limp_recovery.sv
module limp_recovery #(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_ms,
   input  logic              fault_any,
   input  logic [TIME_W-1:0] cfg_recover_ms,
   output logic              limp
);
   logic [TIME_W-1:0] hold_cnt;
   logic [TIME_W:0]   hold_next;

   assign hold_next = {1'b0, hold_cnt} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         limp     <= 1'b0;
         hold_cnt <= '0;
      end else if (fault_any) begin
         limp     <= 1'b1;
         hold_cnt <= '0;
      end else if (limp && tick_ms) begin
         if (hold_next >= {1'b0, cfg_recover_ms}) begin
            limp     <= 1'b0;
            hold_cnt <= '0;
         end else begin
            hold_cnt <= hold_next[TIME_W-1:0];
         end
      end
   end

   // R9: exit only on a tick of an all-clear cycle
   assert_exit_on_clear_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(limp) |-> $past(!fault_any && tick_ms));
   // R9: a fault restarts the hold count and keeps limp
   assert_fault_restarts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_any |=> (limp && hold_cnt == '0));
endmodule

// File: rtl/limp_supervisor.sv
module limp_supervisor #(
   parameter int SENS_W  = 12,
   parameter int RPM_W   = 14,
   parameter int MV_W    = 13,
   parameter int PSI_W   = 8,
   parameter int TIME_W  = 16,
   parameter int ADV_W   = 8,
   parameter int RUN_RPM = 400,
   parameter int ZERO_MV = 500,
   parameter int SPAN_MV = 4000
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick_ms,
   input  logic [SENS_W-1:0]       map_val,
   input  logic [SENS_W-1:0]       tps_val,
   input  logic [SENS_W-1:0]       clt_val,
   input  logic [SENS_W-1:0]       iat_val,
   input  logic [SENS_W-1:0]       vbat_val,
   input  logic [RPM_W-1:0]        rpm,
   input  logic                    expander_fault,
   input  logic                    oil_sw,
   input  logic [MV_W-1:0]         oil_mv,
   input  logic [SENS_W-1:0]       cfg_map_min,
   input  logic [SENS_W-1:0]       cfg_map_max,
   input  logic [SENS_W-1:0]       cfg_tps_min,
   input  logic [SENS_W-1:0]       cfg_tps_max,
   input  logic [SENS_W-1:0]       cfg_clt_max,
   input  logic [SENS_W-1:0]       cfg_iat_max,
   input  logic [SENS_W-1:0]       cfg_vbat_min,
   input  logic [1:0]              cfg_oil_mode,
   input  logic                    cfg_oil_active_low,
   input  logic [PSI_W-1:0]        cfg_oil_full_psi,
   input  logic [PSI_W-1:0]        cfg_oil_min_psi,
   input  logic [TIME_W-1:0]       cfg_start_ms,
   input  logic [TIME_W-1:0]       cfg_recover_ms,
   input  logic [RPM_W-1:0]        cfg_limp_rev,
   input  logic signed [ADV_W-1:0] cfg_adv_cap,
   input  logic [RPM_W-1:0]        req_rev,
   input  logic signed [ADV_W-1:0] req_adv,
   output logic [6:0]              fault_mask,
   output logic                    limp_active,
   output logic [RPM_W-1:0]        rev_limit,
   output logic signed [ADV_W-1:0] adv_limit,
   output logic                    gear_lock,
   output logic                    tcc_release,
   output logic                    warn_lamp
);
   import limp_pkg::*;

   if (SENS_W < 2)                  begin : g_bad_sens $error("SENS_W too small"); end
   if (RUN_RPM >= (1 << RPM_W))     begin : g_bad_rpm  $error("RPM_W cannot hold RUN_RPM"); end
   if (ZERO_MV >= (1 << MV_W))      begin : g_bad_mv   $error("MV_W cannot hold ZERO_MV"); end
   if (ADV_W < 2 || TIME_W < 2)     begin : g_bad_misc $error("ADV_W/TIME_W too small"); end

   logic [SENS_W-1:0]     s_val [NUM_SENS];
   logic [SENS_W-1:0]     s_lo  [NUM_SENS];
   logic [SENS_W-1:0]     s_hi  [NUM_SENS];
   logic [NUM_SENS-1:0]   sens_bad;
   logic                  oil_bad;
   logic [NUM_FAULTS-1:0] fault_now;

   // Ceiling-only sensors use a floor of zero; floor-only use all ones.
   assign s_val[FB_MAP]  = map_val;   assign s_lo[FB_MAP]  = cfg_map_min;  assign s_hi[FB_MAP]  = cfg_map_max;
   assign s_val[FB_TPS]  = tps_val;   assign s_lo[FB_TPS]  = cfg_tps_min;  assign s_hi[FB_TPS]  = cfg_tps_max;
   assign s_val[FB_CLT]  = clt_val;   assign s_lo[FB_CLT]  = '0;           assign s_hi[FB_CLT]  = cfg_clt_max;
   assign s_val[FB_IAT]  = iat_val;   assign s_lo[FB_IAT]  = '0;           assign s_hi[FB_IAT]  = cfg_iat_max;
   assign s_val[FB_VBAT] = vbat_val;  assign s_lo[FB_VBAT] = cfg_vbat_min; assign s_hi[FB_VBAT] = '1;

   for (genvar i = 0; i < NUM_SENS; i++) begin : g_sens
      limp_range_check #(.W(SENS_W)) u_chk (
         .value (s_val[i]),
         .lo    (s_lo[i]),
         .hi    (s_hi[i]),
         .bad   (sens_bad[i])
      );
   end

   limp_oil_monitor #(
      .RPM_W(RPM_W), .MV_W(MV_W), .PSI_W(PSI_W), .TIME_W(TIME_W),
      .RUN_RPM(RUN_RPM), .ZERO_MV(ZERO_MV), .SPAN_MV(SPAN_MV)
   ) u_oil (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_ms        (tick_ms),
      .rpm            (rpm),
      .oil_sw         (oil_sw),
      .oil_mv         (oil_mv),
      .cfg_mode       (cfg_oil_mode),
      .cfg_active_low (cfg_oil_active_low),
      .cfg_full_psi   (cfg_oil_full_psi),
      .cfg_min_psi    (cfg_oil_min_psi),
      .cfg_start_ms   (cfg_start_ms),
      .oil_fault      (oil_bad)
   );

   assign fault_now = {oil_bad, expander_fault, sens_bad};

   always_ff @(posedge clk) begin
      if (!rst_n) fault_mask <= '0;
      else        fault_mask <= fault_now;
   end

   limp_recovery #(.TIME_W(TIME_W)) u_rec (
      .clk            (clk),
      .rst_n          (rst_n),
      .tick_ms        (tick_ms),
      .fault_any      (|fault_now),
      .cfg_recover_ms (cfg_recover_ms),
      .limp           (limp_active)
   );

   always_comb begin
      if (limp_active) begin
         rev_limit = cfg_limp_rev;
         adv_limit = (req_adv > cfg_adv_cap) ? cfg_adv_cap : req_adv;
      end else begin
         rev_limit = req_rev;
         adv_limit = req_adv;
      end
   end

   assign gear_lock   = limp_active;
   assign tcc_release = limp_active;
   assign warn_lamp   = limp_active;

   // R8: a visible fault always comes with limp
   assert_fault_implies_limp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_mask) |-> limp_active);
   // R2: manifold bit is backed by an out-of-window sample
   assert_map_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fault_mask[FB_MAP] |-> $past(map_val < cfg_map_min || map_val > cfg_map_max));
   // R10: advance never exceeds the cap in limp
   assert_adv_capped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      limp_active |-> (adv_limit <= cfg_adv_cap));
endmodule

// File: tb/tb_limp_supervisor.sv
module tb_limp_supervisor;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_ms = 1'b0;
   logic [11:0] map_val = 500, tps_val = 300, clt_val = 800, iat_val = 300, vbat_val = 130;
   logic [13:0] rpm = 800;
   logic expander_fault = 0, oil_sw = 1;
   logic [12:0] oil_mv = 2500;
   logic [11:0] cfg_map_min = 100, cfg_map_max = 900, cfg_tps_min = 50, cfg_tps_max = 950;
   logic [11:0] cfg_clt_max = 1100, cfg_iat_max = 700, cfg_vbat_min = 110;
   logic [1:0]  cfg_oil_mode = 2'b10;
   logic        cfg_oil_active_low = 1;
   logic [7:0]  cfg_oil_full_psi = 100, cfg_oil_min_psi = 10;
   logic [15:0] cfg_start_ms = 3, cfg_recover_ms = 5;
   logic [13:0] cfg_limp_rev = 3000, req_rev = 6500;
   logic signed [7:0] cfg_adv_cap = 10, req_adv = 30;
   logic [6:0]  fault_mask;
   logic        limp_active, gear_lock, tcc_release, warn_lamp;
   logic [13:0] rev_limit;
   logic signed [7:0] adv_limit;

   int checks = 0, errors = 0;
   bit done = 0;

   string       q_tag[$];
   logic [6:0]  q_mask[$];
   bit          q_limp[$];
   int          q_rev[$];
   int          q_adv[$];

   always #2.5 clk = ~clk;

   limp_supervisor dut (.*);

   // Driver: pushes expectation built from R10/R11, then lets one edge pass.
   task automatic step(input bit tk, input string tag, input logic [6:0] m, input bit l);
      tick_ms = tk;
      q_tag.push_back(tag);
      q_mask.push_back(m);
      q_limp.push_back(l);
      q_rev.push_back(l ? int'(cfg_limp_rev) : int'(req_rev));
      q_adv.push_back(l ? ((req_adv > cfg_adv_cap) ? int'(cfg_adv_cap) : int'(req_adv)) : int'(req_adv));
      @(negedge clk);
   endtask

   task automatic recover(input string tag);
      for (int i = 0; i < 4; i++) step(1, tag, 7'h00, 1);
      step(1, tag, 7'h00, 0);
   endtask

   task automatic check(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Monitor: pops one expectation per edge and compares.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q_tag.size() > 0) begin
            string t;
            bit l;
            t = q_tag.pop_front();
            l = q_limp.pop_front();
            check(t, "fault_mask", int'(fault_mask), int'(q_mask.pop_front()));
            check(t, "limp", int'(limp_active), int'(l));
            check(t, "rev_limit", int'(rev_limit), q_rev.pop_front());
            check(t, "adv_limit", int'(adv_limit), q_adv.pop_front());
            check(t, "flags", int'({gear_lock, tcc_release, warn_lamp}), l ? 7 : 0);
         end
      end
   end

   initial begin
      #(5ns * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step(0, "R1 reset", 7'h00, 0);
      rst_n = 1;
      step(0, "R11 idle", 7'h00, 0);
      // entry and exit timing
      map_val = 950;  step(0, "R8 R2 map high", 7'h01, 1);
      map_val = 500;  recover("R9 exit");
      map_val = 50;   step(0, "R2 map low", 7'h01, 1);
      map_val = 500;
      for (int i = 0; i < 3; i++) step(1, "R9 hold", 7'h00, 1);
      tps_val = 980;  step(0, "R2 tps high", 7'h02, 1);
      tps_val = 300;  recover("R9 restart");
      // inclusive bounds
      map_val = 100; tps_val = 950; step(0, "R2 bounds", 7'h00, 0);
      map_val = 900; tps_val = 50;  clt_val = 1100; iat_val = 700; vbat_val = 110;
      step(0, "R3 bounds", 7'h00, 0);
      clt_val = 1101;     step(0, "R3 clt", 7'h04, 1);
      iat_val = 701;      step(0, "R3 iat", 7'h0C, 1);
      vbat_val = 109;     step(0, "R3 vbat", 7'h1C, 1);
      expander_fault = 1; step(0, "R4 expander", 7'h3C, 1);
      req_adv = 5;        step(0, "R10 adv below cap", 7'h3C, 1);
      req_adv = -4;       step(0, "R10 negative adv", 7'h3C, 1);
      map_val = 500; tps_val = 300; clt_val = 800; iat_val = 300; vbat_val = 130;
      expander_fault = 0; req_adv = 30;
      recover("R9 multi clear");
      req_rev = 7000;     step(0, "R11 pass rev", 7'h00, 0);
      // oil gating
      rpm = 300;          step(0, "R5 slow", 7'h00, 0);
      oil_mv = 600;       step(1, "R5 gated", 7'h00, 0);
      rpm = 400;
      for (int i = 0; i < 3; i++) step(1, "R5 delay", 7'h00, 0);
      step(0, "R5 armed R6 low", 7'h40, 1);
      rpm = 399;          step(0, "R5 drop", 7'h00, 1);
      rpm = 800;          step(0, "R5 restart", 7'h00, 1);
      oil_mv = 2500;      recover("R5 rearm");
      oil_mv = 900;       step(0, "R6 at 10psi", 7'h00, 0);
      oil_mv = 899;       step(0, "R6 below 10psi", 7'h40, 1);
      oil_mv = 300;       step(0, "R6 under zero", 7'h40, 1);
      oil_mv = 2500;      recover("R6 clear");
      cfg_oil_mode = 2'b01; oil_sw = 1; step(0, "R7 sw high ok", 7'h00, 0);
      oil_sw = 0;                  step(0, "R7 sw low fault", 7'h40, 1);
      cfg_oil_active_low = 0;      step(0, "R7 polarity ok", 7'h00, 1);
      oil_sw = 1;                  step(0, "R7 polarity fault", 7'h40, 1);
      cfg_oil_mode = 2'b00;        step(0, "R7 disabled", 7'h00, 1);
      recover("R7 clear");
      step(0, "R11 final", 7'h00, 0);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule